// File: doc/BRIEF.md
# Comparator Channel Digital Back-End

This block conditions the output of one analog comparator channel in the clock domain of the chip. The raw comparator decision arrives as an asynchronous single bit. It may be inverted when the channel's inputs are swapped. It then crosses into the clock domain through a two-flop synchronizer and fills a short history register, which a majority vote of selectable length reads. The voted result is the channel's status output. Changes of that result, or the end of a one-off measurement, can raise a sticky interrupt.

The channel runs in one of two modes. In continuous mode it samples every clock and updates its result once the vote window holds enough fresh samples. In single-shot mode it waits for a start pulse, collects exactly one window of new samples, latches the vote, pulses a done flag and goes idle again. A 32-bit control word is registered inside the block. It also chooses what drives the comparator's I/O output: nothing, the unsynchronized decision, or the filtered result. Control fields that belong to the analog side (input selects, speed, hysteresis, standby behaviour) are only registered and exported.

Top module: `cmp_chan_ctrl`

## Requirements
- R1: While reset is asserted, and until the control word changes after reset, cmp_result, cmp_ready, ss_done, cmp_irq, pin_out and all exported analog fields are 0.
- R2: When control bit 15 is 1, the comparator decision is inverted before it reaches both the synchronizer and the unsynchronized output path.
- R3: Control bits 26:24 choose the vote: 0 passes the newest synchronized sample, 1 outputs 1 when at least 2 of the newest 3 samples are 1, 2 outputs 1 when at least 3 of the newest 5 are 1, and any other value behaves like 0 (window of 1).
- R4: cmp_ready is 1 exactly when control bit 1 (enable) is set and the number of samples taken since the history was last emptied has reached the window size (1, 3 or 5). It is 0 while the channel is disabled.
- R5: In continuous mode (bit 2 clear, bit 1 set), a sample is shifted in on every clock and cmp_result follows the vote once ready. Clearing bit 1 empties the history and forces cmp_result to 0. The first result after enabling raises no interrupt.
- R6: Control bits 4:3 choose the interrupt event: 0 any change of cmp_result, 1 a change to 1, 2 a change to 0, 3 the completion of a single-shot measurement.
- R7: With bits 4:3 equal to 3 in continuous mode, cmp_irq never sets.
- R8: In single-shot mode (bit 2 set), an ss_start pulse while idle starts a capture of one full window of new samples. One clock after the last sample, the vote is latched into cmp_result and ss_done is 1 for exactly one cycle. ss_start is ignored while a capture is running and in continuous mode.
- R9: cmp_irq stays 1 until irq_clr is 1 on a clock edge. An event on that same edge keeps it set.
- R10: Control bits 29:28 route pin_out: 0 or 3 drive it low, 1 drives it from the (possibly inverted) unsynchronized decision, 2 drives it from cmp_result.
- R11: The exported fields follow the registered control word: neg_sel = bits 10:8, pos_sel = bits 14:12, speed_sel = bits 17:16, hyst_en = bit 19, stby_run = bit 6.
- R12: A new control word takes effect on the clock edge after it is applied, including on the routing of pin_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_word | input | 32 | Channel configuration word |
| cmp_raw | input | 1 | Asynchronous comparator decision |
| ss_start | input | 1 | Single-shot start request, one-cycle pulse |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt flag |
| cmp_result | output | 1 | Synchronized, filtered comparator result |
| cmp_ready | output | 1 | Filter window filled with valid samples |
| ss_done | output | 1 | One-cycle end-of-measurement pulse |
| cmp_irq | output | 1 | Sticky interrupt flag |
| pin_out | output | 1 | Comparator I/O output |
| neg_sel | output | 3 | Exported negative input select |
| pos_sel | output | 3 | Exported positive input select |
| speed_sel | output | 2 | Exported speed setting |
| hyst_en | output | 1 | Exported hysteresis enable |
| stby_run | output | 1 | Exported run-in-standby setting |

## Verification
The assertions watch properties that hold on every cycle against the registered control word: pin_out is low or follows the unsynchronized decision as the routing field says, ready stays low while disabled, the done flag is a single-cycle pulse that appears only in single-shot mode, the interrupt flag stays set until cleared, and the exported analog fields follow the control word. Only the bench scenarios can show the sample-accurate behaviour of the majority vote, such as a one- or two-cycle glitch rejected by the 3- and 5-sample windows. The same holds for the exact cycle on which a single-shot capture ends, the choice of interrupt event, the missing interrupt on the first result after enable, and the one-cycle latency of a new configuration.

// File: rtl/cmp_chan_pkg.sv
package cmp_chan_pkg;

    localparam int CTRL_W = 32;
    localparam int HIST_W = 5;
    localparam int CNT_W  = $clog2(HIST_W + 1);

    typedef enum logic [1:0] {
        IRQ_ANY  = 2'd0,
        IRQ_RISE = 2'd1,
        IRQ_FALL = 2'd2,
        IRQ_EOC  = 2'd3
    } irq_sel_e;

    typedef enum logic [1:0] {
        ROUTE_OFF   = 2'd0,
        ROUTE_ASYNC = 2'd1,
        ROUTE_SYNC  = 2'd2,
        ROUTE_RSVD  = 2'd3
    } route_e;

    typedef struct packed {
        logic       en;
        logic       single;
        irq_sel_e   sel;
        logic       swap;
        logic [2:0] flen;
        route_e     route;
        logic [2:0] neg;
        logic [2:0] pos;
        logic [1:0] speed;
        logic       hyst;
        logic       stby;
    } cfg_t;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             res;
        logic             valid;
        logic             irq;
        logic             done;
    } seq_st_t;

    function automatic cfg_t cfg_decode(input logic [CTRL_W-1:0] w);
        cfg_t c;
        c.en     = w[1];
        c.single = w[2];
        c.sel    = irq_sel_e'(w[4:3]);
        c.swap   = w[15];
        c.flen   = w[26:24];
        c.route  = route_e'(w[29:28]);
        c.neg    = w[10:8];
        c.pos    = w[14:12];
        c.speed  = w[17:16];
        c.hyst   = w[19];
        c.stby   = w[6];
        return c;
    endfunction

    // Number of samples the vote looks at; reserved codes use a window of one.
    function automatic logic [CNT_W-1:0] win_of(input logic [2:0] flen);
        case (flen)
            3'd1:    return CNT_W'(3);
            3'd2:    return CNT_W'(5);
            default: return CNT_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = d_async;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], d_async};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cmp_maj_filter.sv
module cmp_maj_filter
    import cmp_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       shift,
    input  logic       din,
    input  logic [2:0] flen,
    output logic       vote
);
    localparam int ONES_W = $clog2(HIST_W + 1);

    logic [HIST_W-1:0] hist_d, hist_q;
    logic [ONES_W-1:0] ones3, ones5;

    always_comb begin
        hist_d = hist_q;
        if (clear)      hist_d = '0;
        else if (shift) hist_d = {hist_q[HIST_W-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

    always_comb begin
        ones3 = ONES_W'($countones(hist_q[2:0]));
        ones5 = ONES_W'($countones(hist_q[4:0]));
        case (flen)
            3'd1:    vote = (ones3 >= ONES_W'(2));
            3'd2:    vote = (ones5 >= ONES_W'(3));
            default: vote = hist_q[0];
        endcase
    end
endmodule

// File: rtl/cmp_chan_seq.sv
module cmp_chan_seq
    import cmp_chan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cfg_t cfg,
    input  logic vote,
    input  logic start,
    input  logic irq_clr,
    output logic hist_clear,
    output logic hist_shift,
    output logic result,
    output logic ready,
    output logic done,
    output logic irq
);
    seq_st_t          st_d, st_q;
    logic [CNT_W-1:0] win;
    logic             full;
    logic             upd;
    logic             eoc;
    logic             ev;

    always_comb begin
        win        = win_of(cfg.flen);
        full       = (st_q.cnt >= win);
        st_d       = st_q;
        st_d.done  = 1'b0;
        upd        = 1'b0;
        eoc        = 1'b0;
        ev         = 1'b0;
        hist_clear = 1'b0;
        hist_shift = 1'b0;

        if (!cfg.en) begin
            st_d.busy  = 1'b0;
            st_d.cnt   = '0;
            st_d.res   = 1'b0;
            st_d.valid = 1'b0;
            hist_clear = 1'b1;
        end else if (!cfg.single) begin
            st_d.busy  = 1'b0;
            hist_shift = 1'b1;
            if (st_q.cnt < CNT_W'(HIST_W)) st_d.cnt = st_q.cnt + 1'b1;
            upd = full;
        end else if (st_q.busy) begin
            if (full) begin
                upd       = 1'b1;
                eoc       = 1'b1;
                st_d.done = 1'b1;
                st_d.busy = 1'b0;
            end else begin
                hist_shift = 1'b1;
                st_d.cnt   = st_q.cnt + 1'b1;
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end

        if (upd) begin
            if (st_q.valid && (vote != st_q.res)) begin
                case (cfg.sel)
                    IRQ_ANY:  ev = 1'b1;
                    IRQ_RISE: ev = vote;
                    IRQ_FALL: ev = ~vote;
                    default:  ev = 1'b0;
                endcase
            end
            st_d.res   = vote;
            st_d.valid = 1'b1;
        end
        if (eoc && (cfg.sel == IRQ_EOC)) ev = 1'b1;

        st_d.irq = ev | (st_q.irq & ~irq_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result = st_q.res;
    assign ready  = cfg.en & full;
    assign done   = st_q.done;
    assign irq    = st_q.irq;
endmodule

// File: rtl/cmp_chan_ctrl.sv
module cmp_chan_ctrl
    import cmp_chan_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              cmp_raw,
    input  logic              ss_start,
    input  logic              irq_clr,
    output logic              cmp_result,
    output logic              cmp_ready,
    output logic              ss_done,
    output logic              cmp_irq,
    output logic              pin_out,
    output logic [2:0]        neg_sel,
    output logic [2:0]        pos_sel,
    output logic [1:0]        speed_sel,
    output logic              hyst_en,
    output logic              stby_run
);
    cfg_t cfg_d, cfg_q;
    logic cmp_cond;
    logic cmp_synced;
    logic vote;
    logic hist_clear;
    logic hist_shift;
    logic unused_ctrl_bits;

    always_comb cfg_d = cfg_decode(ctrl_word);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign unused_ctrl_bits = ^{ctrl_word[0], ctrl_word[5], ctrl_word[7], ctrl_word[11],
                                ctrl_word[18], ctrl_word[23:20], ctrl_word[27],
                                ctrl_word[31:30]};

    // Swap inverts the decision ahead of both output paths.
    assign cmp_cond = cmp_raw ^ cfg_q.swap;

    cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (cmp_cond),
        .q_sync  (cmp_synced)
    );

    cmp_maj_filter u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (hist_clear),
        .shift (hist_shift),
        .din   (cmp_synced),
        .flen  (cfg_q.flen),
        .vote  (vote)
    );

    cmp_chan_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg_q),
        .vote       (vote),
        .start      (ss_start),
        .irq_clr    (irq_clr),
        .hist_clear (hist_clear),
        .hist_shift (hist_shift),
        .result     (cmp_result),
        .ready      (cmp_ready),
        .done       (ss_done),
        .irq        (cmp_irq)
    );

    always_comb begin
        case (cfg_q.route)
            ROUTE_ASYNC: pin_out = cmp_cond;
            ROUTE_SYNC:  pin_out = cmp_result;
            default:     pin_out = 1'b0;
        endcase
    end

    assign neg_sel   = cfg_q.neg;
    assign pos_sel   = cfg_q.pos;
    assign speed_sel = cfg_q.speed;
    assign hyst_en   = cfg_q.hyst;
    assign stby_run  = cfg_q.stby;
endmodule

// File: rtl/cmp_chan_chk.sv
module cmp_chan_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] ctrl_word,
    input logic        cmp_raw,
    input logic        ss_start,
    input logic        irq_clr,
    input logic        cmp_result,
    input logic        cmp_ready,
    input logic        ss_done,
    input logic        cmp_irq,
    input logic        pin_out,
    input logic [2:0]  neg_sel,
    input logic [2:0]  pos_sel,
    input logic [1:0]  speed_sel,
    input logic        hyst_en,
    input logic        stby_run
);
    // Cycles since reset release, saturating; $past depth never exceeds it.
    logic [1:0] up_q;
    logic       unused_chk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         up_q <= '0;
        else if (up_q != 3) up_q <= up_q + 2'd1;
    end

    assign unused_chk = ^{ss_start, cmp_result};

    assert_route_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q >= 1 && ($past(ctrl_word[29:28]) == 2'd0 || $past(ctrl_word[29:28]) == 2'd3))
        |-> !pin_out);

    assert_route_async_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q >= 1 && $past(ctrl_word[29:28]) == 2'd1)
        |-> (pin_out == (cmp_raw ^ $past(ctrl_word[15]))));

    assert_ready_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q >= 1 && !$past(ctrl_word[1])) |-> !cmp_ready);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ss_done |=> !ss_done);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q >= 2 && ss_done) |-> $past(ctrl_word[2], 2));

    assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_irq && !irq_clr) |=> cmp_irq);

    assert_export_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q >= 1) |-> (neg_sel == $past(ctrl_word[10:8]) && pos_sel == $past(ctrl_word[14:12])
                         && speed_sel == $past(ctrl_word[17:16]) && hyst_en == $past(ctrl_word[19])
                         && stby_run == $past(ctrl_word[6])));
endmodule

bind cmp_chan_ctrl cmp_chan_chk u_chk (.*);

// File: tb/cmp_chan_ctrl_tb.sv
module cmp_chan_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ctrl_word = '0;
    logic        cmp_raw = 1'b0;
    logic        ss_start = 1'b0;
    logic        irq_clr = 1'b0;
    logic        cmp_result, cmp_ready, ss_done, cmp_irq, pin_out;
    logic [2:0]  neg_sel, pos_sel;
    logic [1:0]  speed_sel;
    logic        hyst_en, stby_run;

    int n_chk  = 0;
    int n_fail = 0;
    bit mon_on = 1'b0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cmp_chan_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .cmp_raw(cmp_raw),
        .ss_start(ss_start), .irq_clr(irq_clr), .cmp_result(cmp_result),
        .cmp_ready(cmp_ready), .ss_done(ss_done), .cmp_irq(cmp_irq), .pin_out(pin_out),
        .neg_sel(neg_sel), .pos_sel(pos_sel), .speed_sel(speed_sel),
        .hyst_en(hyst_en), .stby_run(stby_run)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int f_win(input logic [2:0] fl);
        return (fl == 3'd1) ? 3 : (fl == 3'd2) ? 5 : 1;
    endfunction

    function automatic logic f_vote(input logic [4:0] h, input logic [2:0] fl);
        if (fl == 3'd1) return ($countones(h[2:0]) >= 2);
        if (fl == 3'd2) return ($countones(h) >= 3);
        return h[0];
    endfunction

    // Reference model built from the requirements.
    logic [31:0] m_ctrl;
    logic        m_s1, m_s2, m_busy, m_res, m_valid, m_irq, m_done;
    logic [4:0]  m_hist;
    int          m_cnt;
    logic        t_upd, t_eoc, t_ev, t_new;
    int          t_win;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl = '0; m_s1 = 0; m_s2 = 0; m_busy = 0; m_res = 0; m_valid = 0;
            m_irq = 0; m_done = 0; m_hist = '0; m_cnt = 0;
        end else begin
            t_win = f_win(m_ctrl[26:24]);
            t_new = f_vote(m_hist, m_ctrl[26:24]);
            t_upd = 0; t_eoc = 0; t_ev = 0;
            m_done = 0;
            if (!m_ctrl[1]) begin
                m_hist = '0; m_cnt = 0; m_busy = 0; m_res = 0; m_valid = 0;
            end else if (!m_ctrl[2]) begin
                m_busy = 0;
                t_upd = (m_cnt >= t_win);
                m_hist = {m_hist[3:0], m_s2};
                if (m_cnt < 5) m_cnt++;
            end else if (m_busy) begin
                if (m_cnt >= t_win) begin
                    t_upd = 1; t_eoc = 1; m_done = 1; m_busy = 0;
                end else begin
                    m_hist = {m_hist[3:0], m_s2};
                    m_cnt++;
                end
            end else if (ss_start) begin
                m_busy = 1; m_cnt = 0;
            end
            if (t_upd) begin
                if (m_valid && t_new != m_res) begin
                    case (m_ctrl[4:3])
                        2'd0: t_ev = 1;
                        2'd1: t_ev = t_new;
                        2'd2: t_ev = !t_new;
                        default: t_ev = 0;
                    endcase
                end
                m_res = t_new; m_valid = 1;
            end
            if (t_eoc && m_ctrl[4:3] == 2'd3) t_ev = 1;
            m_irq = t_ev | (m_irq & !irq_clr);
            m_s2 = m_s1;
            m_s1 = cmp_raw ^ m_ctrl[15];
            m_ctrl = ctrl_word;
        end
    end

    // Per-cycle comparison against the model, at the falling edge.
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            chk("R3", "result", cmp_result, m_res);
            chk("R4", "ready", cmp_ready,
                (m_ctrl[1] && m_cnt >= f_win(m_ctrl[26:24])) ? 1 : 0);
            chk("R8", "done", ss_done, m_done);
            chk("R6", "irq", cmp_irq, m_irq);
            chk("R10", "pin", pin_out,
                (m_ctrl[29:28] == 2'd1) ? (cmp_raw ^ m_ctrl[15]) :
                (m_ctrl[29:28] == 2'd2) ? m_res : 1'b0);
            chk("R11", "analog", {neg_sel, pos_sel, speed_sel, hyst_en, stby_run},
                {m_ctrl[10:8], m_ctrl[14:12], m_ctrl[17:16], m_ctrl[19], m_ctrl[6]});
        end
    end

    task automatic step();
        @(negedge clk);
        #2;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired R8 actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        steps(3);
        chk("R1", "reset result", cmp_result, 0);
        chk("R1", "reset ready", cmp_ready, 0);
        chk("R1", "reset done", ss_done, 0);
        chk("R1", "reset irq", cmp_irq, 0);
        chk("R1", "reset pin", pin_out, 0);
        chk("R1", "reset analog", {neg_sel, pos_sel, speed_sel, hyst_en, stby_run}, 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        steps(2);

        // R12: new routing visible only after the next edge
        ctrl_word = 32'h1000_0000; cmp_raw = 1'b1;
        #1 chk("R12", "pin before edge", pin_out, 0);
        step();
        chk("R12", "pin after edge", pin_out, 1);

        // R2: swap inverts the async path and the filtered path
        ctrl_word = 32'h1000_8000;
        step();
        chk("R2", "async inverted pin", pin_out, 0);
        ctrl_word = 32'h2000_8002; cmp_raw = 1'b0;
        steps(8);
        chk("R2", "filtered inverted", cmp_result, 1);
        chk("R10", "sync route pin", pin_out, 1);
        chk("R5", "no irq on first result", cmp_irq, 0);

        // R7: end-of-comparison select in continuous mode never fires
        ctrl_word = 32'h0000_001A;
        for (int k = 0; k < 4; k++) begin
            cmp_raw = ~cmp_raw;
            steps(6);
        end
        chk("R7", "no irq eoc continuous", cmp_irq, 0);

        // R9: sticky flag and clear
        ctrl_word = 32'h0000_0002; cmp_raw = 1'b0;
        steps(6);
        irq_clr = 1'b1; step(); irq_clr = 1'b0; step();
        cmp_raw = 1'b1;
        steps(6);
        chk("R9", "irq set by change", cmp_irq, 1);
        steps(3);
        chk("R9", "irq held", cmp_irq, 1);
        irq_clr = 1'b1; step(); irq_clr = 1'b0; step();
        chk("R9", "irq cleared", cmp_irq, 0);

        // R8: single-shot, 5-sample window, eoc interrupt
        ctrl_word = 32'h0200_001E;
        steps(3);
        ss_start = 1'b1;
        for (int k = 1; k <= 8; k++) begin
            step();
            ss_start = (k == 2);
            chk("R8", "single-shot done timing", ss_done, (k == 7) ? 1 : 0);
            if (k == 7) begin
                chk("R6", "eoc irq", cmp_irq, 1);
                chk("R8", "latched result", cmp_result, 1);
            end
        end
        irq_clr = 1'b1; step(); irq_clr = 1'b0;

        // R3: glitch rejection by the 3- and 5-sample votes
        ctrl_word = 32'h0100_0002; cmp_raw = 1'b0;
        steps(10);
        cmp_raw = 1'b1; step(); cmp_raw = 1'b0;
        for (int k = 0; k < 8; k++) begin
            step();
            chk("R3", "maj3 rejects 1-cycle glitch", cmp_result, 0);
        end
        ctrl_word = 32'h0200_0002;
        steps(8);
        cmp_raw = 1'b1; steps(2); cmp_raw = 1'b0;
        for (int k = 0; k < 8; k++) begin
            step();
            chk("R3", "maj5 rejects 2-cycle glitch", cmp_result, 0);
        end

        // Random phase checked by the model
        for (int seg = 0; seg < 60; seg++) begin
            logic [31:0] w;
            int len;
            w = $urandom();
            w[1] = ($urandom_range(0, 7) != 0);
            case ($urandom_range(0, 3))
                0: w[26:24] = 3'd0;
                1: w[26:24] = 3'd1;
                2: w[26:24] = 3'd2;
                default: w[26:24] = 3'($urandom_range(3, 7));
            endcase
            ctrl_word = w;
            len = $urandom_range(20, 80);
            for (int c = 0; c < len; c++) begin
                if ($urandom_range(0, 3) == 0) cmp_raw = ~cmp_raw;
                ss_start = ($urandom_range(0, 9) == 0);
                irq_clr = ($urandom_range(0, 15) == 0);
                step();
            end
            ss_start = 1'b0; irq_clr = 1'b0;
        end
        steps(3);
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule